// File: doc/BRIEF.md
# Accelerator Slave-Bus Wrapper

This block lets a compute core with a start/done handshake sit on a simple memory-mapped slave bus. Each array operand of the core lives in its own single-port data RAM, and each scalar operand lives in its own operand register. A control word starts the core, and a status word reports completion. Software loads the input RAMs and input scalars, sets the start bit, polls the done bit, and then reads back the output scalars and output RAMs.

A single busy flag decides who owns the storage. It rises together with the start pulse and falls when the core reports done. While it is high, the core drives the address, data and enables of every RAM and operand register. While it is low, the bus drives them through multiplexers. The two sides therefore never reach the same storage in the same cycle.

Bus address layout: bits [14:11] select a region. Region 0 holds the registers, and regions 1 to NUM_RAMS hold RAMs 0 to NUM_RAMS-1. Bits [9:2] give the word index. In region 0 the word indices are:

- word 0: control, where bit 0 is start.
- word 1: status, where bit 0 is done and bit 1 is busy.
- words 2 onward: the operand registers, in order.

Writes are accepted in the cycle they are presented. Read data comes back exactly one cycle after the read, with a valid strobe.

Top module: `accel_bus_wrap`

## Requirements
- R1: While idle, a bus write to a RAM word stores the data. A later bus read of that word returns it, with bus_rvalid high in the cycle after bus_rd and low otherwise.
- R2: While idle, a bus write to operand register k (region 0, word 2+k) stores the data, and a bus read returns it.
- R3: Writing control word 0 with bit 0 set asserts core_start for exactly one cycle, starting the cycle after the write. Writing it with bit 0 clear causes no start.
- R4: Status bit 0 (done) becomes 1 after core_done is seen while busy. It stays 1 until the next start, which clears it.
- R5: core_busy rises in the same cycle as core_start and stays high until core_done. Status bit 1 reads as busy.
- R6: While busy, the core reads and writes the RAMs through its own ports, and the data the core wrote is visible to the bus after done.
- R7: While busy, the core may write operand registers through core_reg_we, and the new values are visible to the bus after done.
- R8: Bus writes to RAMs or operand registers while busy are ignored.
- R9: Bus reads of RAMs or operand registers while busy return zero.
- R10: A start write while busy produces no second core_start pulse.
- R11: Bus accesses to a region above NUM_RAMS are ignored, and reads return zero.
- R12: After reset, core_start and core_busy are low and the status word reads zero.
- R13: Each RAM region is separate: a write to one RAM does not change the same word index in another RAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Bus byte address |
| bus_wr | input | 1 | Bus write strobe |
| bus_rd | input | 1 | Bus read strobe |
| bus_wdata | input | DATA_W | Bus write data |
| bus_rdata | output | DATA_W | Bus read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| core_start | output | 1 | One-cycle start pulse to the core |
| core_busy | output | 1 | Ownership flag, high from start to done |
| core_done | input | 1 | Completion pulse from the core |
| core_ram_en | input | NUM_RAMS | Per-RAM core enable |
| core_ram_we | input | NUM_RAMS | Per-RAM core write enable |
| core_ram_addr | input | NUM_RAMS*AW | Per-RAM core word address |
| core_ram_wdata | input | NUM_RAMS*DATA_W | Per-RAM core write data |
| core_ram_rdata | output | NUM_RAMS*DATA_W | Per-RAM read data, one cycle latency |
| core_reg_we | input | NUM_OPND | Per-operand core write enable |
| core_reg_wdata | input | NUM_OPND*DATA_W | Per-operand core write data |
| core_reg_rdata | output | NUM_OPND*DATA_W | Operand register values |

## Verification
The assertions check, on every cycle, the control behaviour:

- the start pulse lasts one cycle;
- busy rises with start and holds until done;
- done sets on finish and stays sticky;
- no restart occurs while busy;
- operand registers stay frozen against bus writes while busy;
- read-valid timing is correct;
- blocked reads return zero.

Only the bench scenarios can show that data moves correctly through the ownership switch. These scenarios cover RAM contents written by the core and seen by the bus after done, RAM words that survive ignored bus writes, separation between RAMs, and silence of unmapped regions.

// File: rtl/accel_wrap_pkg.sv
package accel_wrap_pkg;
   localparam int unsigned CTRL_IDX  = 0;
   localparam int unsigned STAT_IDX  = 1;
   localparam int unsigned OPND_BASE = 2;
   localparam int unsigned START_BIT = 0;
   localparam int unsigned DONE_BIT  = 0;
   localparam int unsigned BUSY_BIT  = 1;
endpackage

// File: rtl/wrap_ctrl.sv
module wrap_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic start_req,
   input  logic core_done,
   output logic start_o,
   output logic busy_o,
   output logic done_o
);
   logic start_q, busy_q, done_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         start_q <= 1'b0;
         busy_q  <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         start_q <= 1'b0;
         if (start_req && !busy_q) begin
            start_q <= 1'b1;
            busy_q  <= 1'b1;
            done_q  <= 1'b0;
         end else if (busy_q && core_done) begin
            busy_q  <= 1'b0;
            done_q  <= 1'b1;
         end
      end
   end

   assign start_o = start_q;
   assign busy_o  = busy_q;
   assign done_o  = done_q;

   a_r3_start_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      start_q |=> !start_q);
   a_r5_busy_with_start: assert property (@(posedge clk) disable iff (!rst_n)
      start_q |-> busy_q);
   a_r5_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q && !core_done |=> busy_q);
   a_r4_done_on_finish: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q && core_done |=> done_q && !busy_q);
   a_r4_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      done_q && !busy_q && !start_req |=> done_q);
   a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |=> !start_q);
endmodule

// File: rtl/wrap_ram.sv
module wrap_ram #(
   parameter int unsigned DEPTH = 256,
   parameter int unsigned WIDTH = 32,
   localparam int unsigned AW   = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             busy,
   input  logic             bus_en,
   input  logic             bus_we,
   input  logic [AW-1:0]    bus_addr,
   input  logic [WIDTH-1:0] bus_wdata,
   input  logic             core_en,
   input  logic             core_we,
   input  logic [AW-1:0]    core_addr,
   input  logic [WIDTH-1:0] core_wdata,
   output logic [WIDTH-1:0] rdata
);
   logic [WIDTH-1:0] mem [DEPTH];
   logic             en, we;
   logic [AW-1:0]    addr;
   logic [WIDTH-1:0] wdata;

   always_comb begin
      if (busy) begin
         en = core_en; we = core_we; addr = core_addr; wdata = core_wdata;
      end else begin
         en = bus_en;  we = bus_we;  addr = bus_addr;  wdata = bus_wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (en) begin
         if (we) mem[addr] <= wdata;
         rdata <= mem[addr];
      end
   end
endmodule

// File: rtl/wrap_oregs.sv
module wrap_oregs #(
   parameter int unsigned NUM   = 4,
   parameter int unsigned WIDTH = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 busy,
   input  logic [NUM-1:0]       bus_we,
   input  logic [WIDTH-1:0]     bus_wdata,
   input  logic [NUM-1:0]       core_we,
   input  logic [NUM*WIDTH-1:0] core_wdata,
   output logic [NUM*WIDTH-1:0] q
);
   for (genvar k = 0; k < NUM; k++) begin : g_reg
      logic [WIDTH-1:0] r;
      always_ff @(posedge clk) begin
         if (!rst_n) r <= '0;
         else if (busy) begin
            if (core_we[k]) r <= core_wdata[k*WIDTH +: WIDTH];
         end else if (bus_we[k]) r <= bus_wdata;
      end
      assign q[k*WIDTH +: WIDTH] = r;

      a_r8_reg_locked: assert property (@(posedge clk) disable iff (!rst_n)
         busy && !core_we[k] |=> $stable(q[k*WIDTH +: WIDTH]));
   end
endmodule

// File: rtl/accel_bus_wrap.sv
module accel_bus_wrap
   import accel_wrap_pkg::*;
#(
   parameter int unsigned NUM_RAMS   = 8,
   parameter int unsigned RAM_DEPTH  = 256,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned NUM_OPND   = 4,
   parameter int unsigned ADDR_W     = 15,
   parameter int unsigned REGION_LSB = 11,
   localparam int unsigned AW        = $clog2(RAM_DEPTH),
   localparam int unsigned REGION_W  = ADDR_W - REGION_LSB
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [ADDR_W-1:0]        bus_addr,
   input  logic                     bus_wr,
   input  logic                     bus_rd,
   input  logic [DATA_W-1:0]        bus_wdata,
   output logic [DATA_W-1:0]        bus_rdata,
   output logic                     bus_rvalid,
   output logic                     core_start,
   output logic                     core_busy,
   input  logic                     core_done,
   input  logic [NUM_RAMS-1:0]      core_ram_en,
   input  logic [NUM_RAMS-1:0]      core_ram_we,
   input  logic [NUM_RAMS*AW-1:0]   core_ram_addr,
   input  logic [NUM_RAMS*DATA_W-1:0] core_ram_wdata,
   output logic [NUM_RAMS*DATA_W-1:0] core_ram_rdata,
   input  logic [NUM_OPND-1:0]      core_reg_we,
   input  logic [NUM_OPND*DATA_W-1:0] core_reg_wdata,
   output logic [NUM_OPND*DATA_W-1:0] core_reg_rdata
);
   if (NUM_RAMS < 1 || NUM_RAMS >= (1 << REGION_W)) begin : g_bad_rams
      $error("NUM_RAMS does not fit the region field");
   end
   if (REGION_LSB <= AW + 2) begin : g_bad_lsb
      $error("REGION_LSB overlaps the word index");
   end
   if (OPND_BASE + NUM_OPND > RAM_DEPTH) begin : g_bad_opnd
      $error("too many operand registers for the index field");
   end

   // ---------------- decode ----------------
   logic [REGION_W-1:0] region;
   logic [AW-1:0]       idx;
   logic                reg_sel, any_ram, blocked;
   logic [NUM_RAMS-1:0] ram_sel;
   logic                unused_addr;

   assign region      = bus_addr[ADDR_W-1:REGION_LSB];
   assign idx         = bus_addr[2 +: AW];
   assign reg_sel     = (region == '0);
   assign unused_addr = ^{bus_addr[REGION_LSB-1:AW+2], bus_addr[1:0]};

   for (genvar i = 0; i < NUM_RAMS; i++) begin : g_sel
      assign ram_sel[i] = (region == REGION_W'(i + 1));
   end
   assign any_ram = |ram_sel;

   // ---------------- control ----------------
   logic start_req, done_flag;
   assign start_req = bus_wr && reg_sel && (idx == AW'(CTRL_IDX)) && bus_wdata[START_BIT];

   wrap_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_req (start_req),
      .core_done (core_done),
      .start_o   (core_start),
      .busy_o    (core_busy),
      .done_o    (done_flag)
   );

   // ---------------- operand registers ----------------
   logic [NUM_OPND-1:0] opnd_bus_we;
   logic                opnd_hit;
   for (genvar k = 0; k < NUM_OPND; k++) begin : g_owe
      assign opnd_bus_we[k] = bus_wr && reg_sel && (idx == AW'(OPND_BASE + k));
   end

   wrap_oregs #(.NUM(NUM_OPND), .WIDTH(DATA_W)) u_oregs (
      .clk        (clk),
      .rst_n      (rst_n),
      .busy       (core_busy),
      .bus_we     (opnd_bus_we),
      .bus_wdata  (bus_wdata),
      .core_we    (core_reg_we),
      .core_wdata (core_reg_wdata),
      .q          (core_reg_rdata)
   );

   // ---------------- RAMs ----------------
   for (genvar i = 0; i < NUM_RAMS; i++) begin : g_ram
      wrap_ram #(.DEPTH(RAM_DEPTH), .WIDTH(DATA_W)) u_ram (
         .clk        (clk),
         .busy       (core_busy),
         .bus_en     ((bus_wr || bus_rd) && ram_sel[i] && !core_busy),
         .bus_we     (bus_wr),
         .bus_addr   (idx),
         .bus_wdata  (bus_wdata),
         .core_en    (core_ram_en[i]),
         .core_we    (core_ram_we[i]),
         .core_addr  (core_ram_addr[i*AW +: AW]),
         .core_wdata (core_ram_wdata[i*DATA_W +: DATA_W]),
         .rdata      (core_ram_rdata[i*DATA_W +: DATA_W])
      );
   end

   // ---------------- bus read path ----------------
   logic [DATA_W-1:0]   reg_val, rd_reg_q, ram_mux;
   logic [REGION_W-1:0] rd_region_q;
   logic                rd_block_q, rvalid_q;

   always_comb begin
      reg_val  = '0;
      opnd_hit = |opnd_bus_we;
      if (idx == AW'(CTRL_IDX)) reg_val[START_BIT] = core_start;
      if (idx == AW'(STAT_IDX)) begin
         reg_val[DONE_BIT] = done_flag;
         reg_val[BUSY_BIT] = core_busy;
      end
      for (int k = 0; k < int'(NUM_OPND); k++) begin
         if (idx == AW'(OPND_BASE + k)) reg_val = core_reg_rdata[k*DATA_W +: DATA_W];
      end
   end

   assign blocked = core_busy && (any_ram ||
                    (reg_sel && idx >= AW'(OPND_BASE) && idx < AW'(OPND_BASE + NUM_OPND)));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rvalid_q    <= 1'b0;
         rd_block_q  <= 1'b0;
         rd_region_q <= '0;
         rd_reg_q    <= '0;
      end else begin
         rvalid_q <= bus_rd;
         if (bus_rd) begin
            rd_block_q  <= blocked;
            rd_region_q <= region;
            rd_reg_q    <= reg_val;
         end
      end
   end

   always_comb begin
      ram_mux = '0;
      for (int i = 0; i < int'(NUM_RAMS); i++) begin
         if (rd_region_q == REGION_W'(i + 1)) ram_mux = core_ram_rdata[i*DATA_W +: DATA_W];
      end
   end

   always_comb begin
      if (!rvalid_q || rd_block_q) bus_rdata = '0;
      else if (rd_region_q == '0)  bus_rdata = rd_reg_q;
      else                         bus_rdata = ram_mux;
   end
   assign bus_rvalid = rvalid_q;

   a_r1_rvalid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd |=> bus_rvalid);
   a_r1_no_stray_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> !bus_rvalid);
   a_r9_blocked_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd && core_busy && any_ram |=> bus_rdata == '0);
   a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd && !reg_sel && !any_ram |=> bus_rdata == '0);
endmodule

// File: tb/sim_accel_bus_wrap.sv
`timescale 1ns/1ps
module sim_accel_bus_wrap;
   localparam int NR = 8, DW = 32, NO = 4, AW = 8;

   logic clk = 1'b0, rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic [14:0]      bus_addr = '0;
   logic             bus_wr = 1'b0, bus_rd = 1'b0;
   logic [DW-1:0]    bus_wdata = '0, bus_rdata;
   logic             bus_rvalid, core_start, core_busy;
   logic             core_done = 1'b0;
   logic [NR-1:0]    core_ram_en = '0, core_ram_we = '0;
   logic [NR*AW-1:0] core_ram_addr = '0;
   logic [NR*DW-1:0] core_ram_wdata = '0, core_ram_rdata;
   logic [NO-1:0]    core_reg_we = '0;
   logic [NO*DW-1:0] core_reg_wdata = '0, core_reg_rdata;

   accel_bus_wrap u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
      .core_start(core_start), .core_busy(core_busy), .core_done(core_done),
      .core_ram_en(core_ram_en), .core_ram_we(core_ram_we), .core_ram_addr(core_ram_addr),
      .core_ram_wdata(core_ram_wdata), .core_ram_rdata(core_ram_rdata),
      .core_reg_we(core_reg_we), .core_reg_wdata(core_reg_wdata), .core_reg_rdata(core_reg_rdata)
   );

   int checks = 0, fails = 0;
   bit reported = 0;
   logic [DW-1:0] exp_q[$];
   string         tag_q[$];

   function automatic logic [14:0] mk(input int region, input int word);
      return {4'(region), 1'b0, 8'(word), 2'b00};
   endfunction

   task automatic chk(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!reported) begin
         reported = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   // monitor: compare returned read data against the scoreboard
   always @(negedge clk) begin
      if (bus_rvalid) begin
         if (exp_q.size() == 0) chk(bus_rdata, 32'hx, "R1 unexpected rvalid");
         else chk(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
      end
   end

   task automatic bus_write(input logic [14:0] a, input logic [DW-1:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [14:0] a, input logic [DW-1:0] exp, input string tag);
      exp_q.push_back(exp); tag_q.push_back(tag);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic core_stub();
      logic [DW-1:0] v;
      while (!core_start) @(negedge clk);
      repeat (20) @(negedge clk);
      core_ram_en[0] = 1'b1; core_ram_we[0] = 1'b0; core_ram_addr[7:0] = 8'd0;
      @(negedge clk);
      v = core_ram_rdata[31:0];
      core_ram_en[0] = 1'b0;
      core_ram_en[1] = 1'b1; core_ram_we[1] = 1'b1;
      core_ram_addr[15:8] = 8'd4; core_ram_wdata[63:32] = v + 32'd1;
      core_reg_we[1] = 1'b1; core_reg_wdata[63:32] = core_reg_rdata[31:0] + 32'h100;
      @(negedge clk);
      core_ram_en = '0; core_ram_we = '0; core_reg_we = '0;
      core_done = 1'b1;
      @(negedge clk);
      core_done = 1'b0;
   endtask

   initial begin
      #(5.0 * 150000);
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(32'(core_start), 0, "R12 start after reset");
      chk(32'(core_busy), 0, "R12 busy after reset");
      bus_read(mk(0, 1), 0, "R12 status after reset");

      // R1 / R13: RAM load and readback
      bus_write(mk(1, 0), 32'h1111_0000);
      bus_write(mk(1, 5), 32'hA5A5_0005);
      bus_write(mk(8, 255), 32'hDEAD_00FF);
      bus_write(mk(2, 5), 32'h0B0B_0005);
      bus_read(mk(1, 0), 32'h1111_0000, "R1 ram0 w0");
      bus_read(mk(8, 255), 32'hDEAD_00FF, "R1 ram7 last word");
      bus_read(mk(1, 5), 32'hA5A5_0005, "R13 ram0 w5 untouched by ram1");
      bus_read(mk(2, 5), 32'h0B0B_0005, "R13 ram1 w5");

      // R2 operand registers
      bus_write(mk(0, 2), 32'h0000_0040);
      bus_write(mk(0, 5), 32'h0000_0033);
      bus_read(mk(0, 2), 32'h0000_0040, "R2 opnd0");
      bus_read(mk(0, 5), 32'h0000_0033, "R2 opnd3");

      // R11 unmapped region
      bus_write(mk(12, 3), 32'hFFFF_FFFF);
      bus_read(mk(12, 3), 0, "R11 unmapped read");

      // R3 control write without start bit
      bus_write(mk(0, 0), 32'h0000_0002);
      chk(32'(core_start), 0, "R3 no start when bit clear");
      chk(32'(core_busy), 0, "R3 still idle");

      fork
         core_stub();
         begin
            bus_write(mk(0, 0), 32'h1);
            chk(32'(core_start), 1, "R3 start pulse");
            chk(32'(core_busy), 1, "R5 busy with start");
            @(negedge clk);
            chk(32'(core_start), 0, "R3 start self-clears");
            bus_write(mk(1, 5), 32'h0);
            bus_write(mk(0, 5), 32'h99);
            bus_read(mk(1, 0), 0, "R9 ram read while busy");
            bus_read(mk(0, 2), 0, "R9 opnd read while busy");
            bus_read(mk(0, 1), 32'h2, "R5 status busy");
            bus_write(mk(0, 0), 32'h1);
            chk(32'(core_start), 0, "R10 no restart while busy");
            chk(32'(core_busy), 1, "R5 busy held");
         end
      join
      chk(32'(core_busy), 0, "R5 busy drops after done");
      bus_read(mk(0, 1), 32'h1, "R4 done set");
      bus_read(mk(2, 4), 32'h1111_0001, "R6 core wrote ram1");
      bus_read(mk(1, 5), 32'hA5A5_0005, "R8 ram write ignored while busy");
      bus_read(mk(0, 5), 32'h33, "R8 opnd write ignored while busy");
      bus_read(mk(0, 3), 32'h140, "R7 core wrote opnd1");
      repeat (5) @(negedge clk);
      bus_read(mk(0, 1), 32'h1, "R4 done sticky");

      bus_write(mk(0, 0), 32'h1);
      bus_read(mk(0, 1), 32'h2, "R4 done cleared by start");
      core_done = 1'b1;
      @(negedge clk);
      core_done = 1'b0;
      bus_read(mk(0, 1), 32'h1, "R4 done after second run");

      repeat (3) @(negedge clk);
      chk(32'(exp_q.size()), 0, "R1 all reads returned");
      finish_run();
   end
endmodule